// File: doc/BRIEF.md
# I2C Write-Only Target Receiver

This block is the receiving end of an I2C bus for write transfers. It oversamples the bus clock and data lines with the system clock. Conditions and clock edges are taken from the synchronised copies of those lines. After a start condition it collects the address byte and compares the 7-bit address with the value on `own_addr`. If the address matches and the transfer is a write, the block acknowledges by pulling the data line low. It then collects data bytes, acknowledges each one and hands each byte to the logic behind it on a single-cycle strobe.

The bus lines are open-drain. The block never drives a line high; it only asserts `sda_drive_low` or `scl_drive_low`, and the pad logic outside turns these into pull-downs. When `stretch_en` is set and the downstream side shows `rx_ready` low at the moment a byte is handed over, the block holds the clock line low. This delays the controller until `rx_ready` returns high. The received byte stays on `rx_data` until the next byte replaces it.

Top module: `i2c_rx_target`

## Requirements
- R1: While reset is applied and right after it is released, `sda_drive_low`, `scl_drive_low` and `rx_valid` are all 0.
- R2: A falling data line while the clock line is high is a start condition. From any state, including halfway through a byte, it restarts address reception from the first bit.
- R3: A rising data line while the clock line is high is a stop condition. It returns the block to idle. Clock pulses that follow a stop without a new start are ignored: no acknowledge and no strobe.
- R4: Bits are sampled on the rising clock edge, MSB first. In the first byte, bits 7..1 are the address and bit 0 is the direction (0 = write). On a match with a write, `sda_drive_low` rises after the clock falls at the end of the eighth bit. It falls after the clock falls at the end of the ninth clock.
- R5: If the address differs from `own_addr`, or the direction bit is 1 (read), the data line is never pulled low. Every later byte is then ignored until the next start or stop.
- R6: Each data byte is assembled MSB first. It is presented on `rx_data` together with a `rx_valid` pulse exactly one cycle long, and `rx_data` keeps the byte until the next one arrives. Several bytes may follow one address.
- R7: Every data byte received after a matching write address is acknowledged in the same window as the address. `rx_valid` is only asserted while `sda_drive_low` is 1.
- R8: With `stretch_en` at 1 and `rx_ready` at 0 when `rx_valid` pulses, `scl_drive_low` is 1 from the next cycle on. It stays 1 until `rx_ready` is 1, and is released one cycle after that.
- R9: With `stretch_en` at 0 the clock line is never pulled low, whatever `rx_ready` does.
- R10: `sda_drive_low` only rises while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address this target answers to |
| stretch_en | input | 1 | Allows clock stretching while downstream is not ready |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| rx_ready | input | 1 | Downstream can take a byte |
| scl_drive_low | output | 1 | Pull the bus clock line low |
| sda_drive_low | output | 1 | Pull the bus data line low |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte on `rx_data` |

## Verification
The bench models the wired-AND bus, so the target's own pull-downs reach its inputs, and it reads the acknowledge bit the way a controller would. One test issues a repeated start after half a data byte. A design that ignored a start outside idle would misread the new address and fail to acknowledge it. Other tests send a second address after a stop with no start, and send read requests and a wrong address. A design that forgot to park in a skip state would acknowledge these or strobe out bytes. The stretch tests hold `rx_ready` low with stretching on and off. A wrong release condition would either hang the controller or pull the clock line when it should not.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a start condition
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_END,  // address complete, waiting for clock low to decide
        ST_ACK,       // holding data low through the acknowledge clock
        ST_DATA,      // shifting in a data byte
        ST_DATA_END,  // data byte complete, waiting for clock low
        ST_HOLD,      // clock held low until downstream is ready
        ST_SKIP       // not addressed, ignore until start or stop
    } rx_state_e;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign line_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_p_q;
        scl_fall  = ~scl_s & scl_p_q;
        bus_start = scl_s & scl_p_q & sda_p_q & ~sda_s;
        bus_stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    end
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              rx_ready,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CNT_W    = $clog2(DATA_W + 1);
    localparam int ADDR_END = ADDR_W;      // index of the last address-byte bit
    localparam int DATA_END = DATA_W - 1;  // index of the last data bit

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  sh;
        logic [DATA_W-1:0]  dat;
        logic               vld;
        logic               sda_low;
        logic               scl_low;
    } rx_regs_t;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    rx_regs_t r_d, r_q;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_out(scl_s)
    );

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_out(sda_s)
    );

    i2c_rx_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (bus_start) begin
            r_d.st      = ST_ADDR;
            r_d.cnt     = '0;
            r_d.sh      = '0;
            r_d.sda_low = 1'b0;
            r_d.scl_low = 1'b0;
        end else if (bus_stop) begin
            r_d.st      = ST_IDLE;
            r_d.sda_low = 1'b0;
            r_d.scl_low = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[DATA_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(ADDR_END)) r_d.st = ST_ADDR_END;
                    end
                end
                ST_ADDR_END: begin
                    if (scl_fall) begin
                        if (r_q.sh[ADDR_W:1] == own_addr && !r_q.sh[0]) begin
                            r_d.sda_low = 1'b1;
                            r_d.st      = ST_ACK;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_low = 1'b0;
                        r_d.cnt     = '0;
                        r_d.st      = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[DATA_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(DATA_END)) r_d.st = ST_DATA_END;
                    end
                end
                ST_DATA_END: begin
                    if (scl_fall) begin
                        r_d.sda_low = 1'b1;
                        r_d.vld     = 1'b1;
                        r_d.dat     = r_q.sh;
                        if (stretch_en && !rx_ready) begin
                            r_d.scl_low = 1'b1;
                            r_d.st      = ST_HOLD;
                        end else begin
                            r_d.st = ST_ACK;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rx_ready || !stretch_en) begin
                        r_d.scl_low = 1'b0;
                        r_d.st      = ST_ACK;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.sh      <= '0;
            r_q.dat     <= '0;
            r_q.vld     <= 1'b0;
            r_q.sda_low <= 1'b0;
            r_q.scl_low <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low = r_q.scl_low;
    assign sda_drive_low = r_q.sda_low;
    assign rx_data       = r_q.dat;
    assign rx_valid      = r_q.vld;
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic stretch_en,
    input logic rx_ready,
    input logic rx_valid,
    input logic sda_drive_low,
    input logic scl_drive_low
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_drive_low && !scl_drive_low && !rx_valid));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sda_drive_low);

    assert_stretch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && stretch_en && !rx_ready) |=> scl_drive_low);

    assert_stretch_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && stretch_en && !rx_ready) |=> scl_drive_low);

    assert_stretch_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && rx_ready) |=> !scl_drive_low);

    assert_no_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stretch_en && $past(!stretch_en)) |-> !scl_drive_low);

    assert_ack_under_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_in);
endmodule

bind i2c_rx_target i2c_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .stretch_en(stretch_en),
    .rx_ready(rx_ready), .rx_valid(rx_valid),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
);

// File: tb/sim_i2c_rx_target.sv
module sim_i2c_rx_target;
    localparam int Q = 8;                       // quarter bus period in clocks
    localparam logic [6:0] MY_ADDR = 7'h4A;

    // {address byte, data byte, expect ack, expect strobe}
    localparam logic [17:0] VEC [0:5] = '{
        {8'h94, 8'hAA, 1'b1, 1'b1},
        {8'h94, 8'h55, 1'b1, 1'b1},
        {8'h94, 8'h00, 1'b1, 1'b1},
        {8'h94, 8'hFF, 1'b1, 1'b1},
        {8'h96, 8'h3C, 1'b0, 1'b0},   // other address
        {8'h95, 8'hC3, 1'b0, 1'b0}    // read request
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic stretch_en = 1'b1, rx_ready = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_drive_low, sda_drive_low, rx_valid;
    logic [7:0] rx_data;
    wire scl_bus = scl_m & ~scl_drive_low;
    wire sda_bus = sda_m & ~sda_drive_low;

    int n_chk = 0, n_err = 0;
    int vld_cnt = 0, hold_cyc = 0, sda_bad = 0;
    logic [7:0] last_byte = '0;
    logic sda_low_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_rx_target u0 (
        .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR), .stretch_en(stretch_en),
        .scl_in(scl_bus), .sda_in(sda_bus), .rx_ready(rx_ready),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vld_cnt   <= vld_cnt + 1;
            last_byte <= rx_data;
        end
        if (scl_drive_low) hold_cyc <= hold_cyc + 1;
        if (sda_drive_low && !sda_low_prev && scl_bus) sda_bad <= sda_bad + 1;
        sda_low_prev <= sda_drive_low;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q);
        scl_m = 1'b1; idle(Q);
        sda_m = 1'b1; idle(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; idle(Q);
        scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        idle(2 * Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic ack_bit(output bit a);
        sda_m = 1'b1; idle(Q);
        scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        idle(Q);
        a = !sda_bus;
        idle(Q);
        scl_m = 1'b0; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit a);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_bit(a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit a;
        int base;
        // R1: reset state
        idle(5);
        chk(sda_drive_low == 1'b0, "R1 sda in reset", sda_drive_low, 0);
        chk(scl_drive_low == 1'b0, "R1 scl in reset", scl_drive_low, 0);
        rst_n = 1'b1;
        idle(3);
        chk(rx_valid == 1'b0 && !sda_drive_low && !scl_drive_low,
            "R1 after reset", {rx_valid, sda_drive_low, scl_drive_low}, 0);
        idle(4 * Q);

        // Table: R4 address ack, R5 mismatch/read, R6 R7 data strobe and ack
        foreach (VEC[k]) begin
            base = vld_cnt;
            bus_start();
            send_byte(VEC[k][17:10], a);
            chk(a == VEC[k][1], "R4 R5 address ack", a, VEC[k][1]);
            send_byte(VEC[k][9:2], a);
            chk(a == VEC[k][1], "R7 R5 data ack", a, VEC[k][1]);
            bus_stop();
            idle(Q);
            chk(vld_cnt - base == int'(VEC[k][0]), "R6 R5 strobe count", vld_cnt - base, VEC[k][0]);
            if (VEC[k][0])
                chk(last_byte == VEC[k][9:2], "R6 data byte", last_byte, VEC[k][9:2]);
        end

        // R3: bytes after a stop without a start are ignored
        base = vld_cnt;
        bus_start();
        send_byte(8'h94, a);
        bus_stop();
        send_byte(8'h94, a);
        chk(a == 1'b0, "R3 no ack after stop", a, 0);
        send_byte(8'h77, a);
        chk(vld_cnt == base, "R3 no strobe after stop", vld_cnt - base, 0);
        idle(Q);

        // R2: repeated start halfway through a byte, then R6 several bytes
        base = vld_cnt;
        bus_start();
        send_byte(8'h94, a);
        for (int i = 7; i >= 4; i--) send_bit(1'b1 ^ i[0]);
        bus_start();
        send_byte(8'h94, a);
        chk(a == 1'b1, "R2 ack after repeated start", a, 1);
        send_byte(8'h5A, a);
        chk(a == 1'b1 && last_byte == 8'h5A, "R2 first byte", last_byte, 8'h5A);
        send_byte(8'h81, a);
        bus_stop();
        idle(Q);
        chk(vld_cnt - base == 2, "R6 two strobes", vld_cnt - base, 2);
        chk(last_byte == 8'h81, "R6 second byte", last_byte, 8'h81);

        // R8: stretch while not ready
        base = vld_cnt;
        rx_ready = 1'b0;
        bus_start();
        send_byte(8'h94, a);
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'hC6 >> i) & 1));
        chk(scl_drive_low == 1'b1, "R8 hold starts", scl_drive_low, 1);
        chk(vld_cnt - base == 1 && last_byte == 8'hC6, "R6 strobe before hold", last_byte, 8'hC6);
        idle(50);
        chk(scl_drive_low == 1'b1, "R8 hold kept", scl_drive_low, 1);
        rx_ready = 1'b1;
        idle(2);
        chk(scl_drive_low == 1'b0, "R8 hold released", scl_drive_low, 0);
        ack_bit(a);
        chk(a == 1'b1, "R8 ack after hold", a, 1);
        bus_stop();
        idle(Q);

        // R9: no stretch when disabled
        base = hold_cyc;
        stretch_en = 1'b0;
        rx_ready   = 1'b0;
        idle(2);
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h3E, a);
        chk(a == 1'b1, "R9 ack without stretch", a, 1);
        bus_stop();
        chk(hold_cyc == base, "R9 clock never pulled", hold_cyc - base, 0);
        rx_ready   = 1'b1;
        stretch_en = 1'b1;
        idle(Q);

        // R10: acknowledge only begins while the clock line is low
        chk(sda_bad == 0, "R10 sda rise under clock low", sda_bad, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule